// File: doc/BRIEF.md
# Sixteen-Operation Stack-Processor ALU

This block is the 32-bit arithmetic-logic unit of a microcoded stack processor. It is purely combinational. It takes two operands, `a` and `b`, and a 4-bit operation code. In the same cycle it returns a result word and a flag that is high when that word is zero. Whatever drives the operation code sits outside the block, whether that is a microcode field or the low bits of a register.

The sixteen operations cover five groups:
- operand pass-through and bitwise complement;
- two's-complement add and subtract;
- set-on-compare, in signed and unsigned forms, which returns a boolean word;
- bitwise logic, plus a left shift and an arithmetic right shift by a variable amount;
- a single-cycle multiply that keeps the low word, and sign extension from a byte or a halfword.

Top module: `stk_alu`

## Requirements
- R1: Code 0x0 returns `a` unchanged.
- R2: Code 0x1 returns the bitwise complement of `a`.
- R3: Code 0x2 returns a+b and code 0x3 returns a-b. Both wrap modulo 2^32.
- R4: Codes 0x4 (a>b) and 0x5 (a<b) compare the operands as two's-complement numbers. Each returns 32'd1 when true and 32'd0 when false.
- R5: Codes 0x6 (a>b) and 0x7 (a<b) compare the operands as unsigned numbers. Each returns 32'd1 when true and 32'd0 when false, and both return 0 when a equals b.
- R6: Codes 0x8, 0x9 and 0xA return the bitwise AND, OR and XOR of `a` and `b`.
- R7: Code 0xB shifts `a` left by b[4:0] places and fills with zeros. Bits b[31:5] have no effect.
- R8: Code 0xC shifts `a` right by b[4:0] places and fills with copies of a[31].
- R9: Code 0xD returns the low 32 bits of the product a*b.
- R10: Code 0xE copies a[7] into bits 31:8 above a[7:0]. Code 0xF copies a[15] into bits 31:16 above a[15:0].
- R11: Codes 0x1, 0xE and 0xF ignore `b`.
- R12: `zero` is 1 exactly when `y` is 32'd0, for every code.
- R13: The outputs follow any input change with no clock edge in between.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| a | input | 32 | First operand |
| b | input | 32 | Second operand; b[4:0] is the shift amount |
| op | input | 4 | Operation code |
| y | output | 32 | Result word |
| zero | output | 1 | High when the result is all zeros |

## Verification
The comparisons are tried on three kinds of operand pair:
- pairs whose sign bits differ, where the signed and unsigned verdicts disagree;
- pairs near the 0x7FFFFFFF/0x80000000 boundary, which catch a compare taken from the raw difference sign;
- equal pairs, which catch a greater-than built as the plain negation of less-than.

The add, subtract and multiply vectors are chosen to wrap past 2^32. This tells a truncated result apart from an off-by-carry result.

Shifts are driven with b[31:5] set, and with the maximum amount. This shows whether only b[4:0] is used and whether the fill bit is right.

The sign-extension and complement vectors are repeated with different `b` values, to show that `b` has no effect on them.

// File: rtl/stk_alu_pkg.sv
package stk_alu_pkg;

    typedef enum logic [3:0] {
        OP_PASS = 4'h0,
        OP_INV  = 4'h1,
        OP_ADD  = 4'h2,
        OP_SUB  = 4'h3,
        OP_SGT  = 4'h4,
        OP_SLT  = 4'h5,
        OP_UGT  = 4'h6,
        OP_ULT  = 4'h7,
        OP_AND  = 4'h8,
        OP_OR   = 4'h9,
        OP_XOR  = 4'hA,
        OP_SHL  = 4'hB,
        OP_SAR  = 4'hC,
        OP_MUL  = 4'hD,
        OP_SXB  = 4'hE,
        OP_SXH  = 4'hF
    } alu_op_e;

    typedef struct packed {
        logic slt;
        logic sgt;
        logic ult;
        logic ugt;
    } cmp_flags_t;

endpackage

// File: rtl/stk_alu_addsub.sv
module stk_alu_addsub
    import stk_alu_pkg::*;
#(
    parameter int W = 32
) (
    input  logic [W-1:0] a_i,
    input  logic [W-1:0] b_i,
    output logic [W-1:0] sum_o,
    output logic [W-1:0] diff_o,
    output cmp_flags_t   cmp_o
);
    logic [W:0]   diff_wide;
    logic         no_borrow;
    logic         equal;
    logic         sign_split;

    always_comb begin
        sum_o      = a_i + b_i;
        // one adder serves subtraction and every compare
        diff_wide  = {1'b0, a_i} + {1'b0, ~b_i} + {{W{1'b0}}, 1'b1};
        diff_o     = diff_wide[W-1:0];
        no_borrow  = diff_wide[W];
        equal      = (diff_o == '0);
        sign_split = a_i[W-1] ^ b_i[W-1];

        cmp_o.ult  = ~no_borrow;
        cmp_o.ugt  = no_borrow & ~equal;
        cmp_o.slt  = sign_split ? a_i[W-1] : diff_o[W-1];
        cmp_o.sgt  = ~cmp_o.slt & ~equal;
    end
endmodule

// File: rtl/stk_alu_shift.sv
module stk_alu_shift #(
    parameter int W = 32
) (
    input  logic [W-1:0]         a_i,
    input  logic [$clog2(W)-1:0] amt_i,
    output logic [W-1:0]         shl_o,
    output logic [W-1:0]         sar_o
);
    localparam int SW = $clog2(W);

    logic [W-1:0] lstage [0:SW];
    logic [W-1:0] rstage [0:SW];

    assign lstage[0] = a_i;
    assign rstage[0] = a_i;

    // log-depth barrel: stage k moves by 2**k when amt bit k is set
    for (genvar k = 0; k < SW; k++) begin : g_stage
        localparam int SH = 1 << k;
        assign lstage[k+1] = amt_i[k] ? {lstage[k][W-1-SH:0], {SH{1'b0}}}
                                      : lstage[k];
        assign rstage[k+1] = amt_i[k] ? {{SH{a_i[W-1]}}, rstage[k][W-1:SH]}
                                      : rstage[k];
    end

    assign shl_o = lstage[SW];
    assign sar_o = rstage[SW];
endmodule

// File: rtl/stk_alu_bitops.sv
module stk_alu_bitops #(
    parameter int W = 32
) (
    input  logic [W-1:0] a_i,
    input  logic [W-1:0] b_i,
    output logic [W-1:0] and_o,
    output logic [W-1:0] or_o,
    output logic [W-1:0] xor_o,
    output logic [W-1:0] inv_o,
    output logic [W-1:0] mul_o,
    output logic [W-1:0] sxb_o,
    output logic [W-1:0] sxh_o
);
    localparam int BYTE_W = 8;
    localparam int HALF_W = 16;

    always_comb begin
        and_o = a_i & b_i;
        or_o  = a_i | b_i;
        xor_o = a_i ^ b_i;
        inv_o = ~a_i;
        mul_o = a_i * b_i;
        sxb_o = {{(W-BYTE_W){a_i[BYTE_W-1]}}, a_i[BYTE_W-1:0]};
        sxh_o = {{(W-HALF_W){a_i[HALF_W-1]}}, a_i[HALF_W-1:0]};
    end
endmodule

// File: rtl/stk_alu.sv
module stk_alu
    import stk_alu_pkg::*;
#(
    parameter int W = 32
) (
    input  logic [W-1:0] a,
    input  logic [W-1:0] b,
    input  logic [3:0]   op,
    output logic [W-1:0] y,
    output logic         zero
);
    localparam int SW = $clog2(W);

    logic [W-1:0] sum_w, diff_w, shl_w, sar_w;
    logic [W-1:0] and_w, or_w, xor_w, inv_w, mul_w, sxb_w, sxh_w;
    cmp_flags_t   cmp_w;
    logic [W-1:0] y_d;

    stk_alu_addsub #(.W(W)) u_addsub (
        .a_i    (a),
        .b_i    (b),
        .sum_o  (sum_w),
        .diff_o (diff_w),
        .cmp_o  (cmp_w)
    );

    stk_alu_shift #(.W(W)) u_shift (
        .a_i   (a),
        .amt_i (b[SW-1:0]),
        .shl_o (shl_w),
        .sar_o (sar_w)
    );

    stk_alu_bitops #(.W(W)) u_bitops (
        .a_i   (a),
        .b_i   (b),
        .and_o (and_w),
        .or_o  (or_w),
        .xor_o (xor_w),
        .inv_o (inv_w),
        .mul_o (mul_w),
        .sxb_o (sxb_w),
        .sxh_o (sxh_w)
    );

    always_comb begin
        unique case (alu_op_e'(op))
            OP_PASS: y_d = a;
            OP_INV:  y_d = inv_w;
            OP_ADD:  y_d = sum_w;
            OP_SUB:  y_d = diff_w;
            OP_SGT:  y_d = {{(W-1){1'b0}}, cmp_w.sgt};
            OP_SLT:  y_d = {{(W-1){1'b0}}, cmp_w.slt};
            OP_UGT:  y_d = {{(W-1){1'b0}}, cmp_w.ugt};
            OP_ULT:  y_d = {{(W-1){1'b0}}, cmp_w.ult};
            OP_AND:  y_d = and_w;
            OP_OR:   y_d = or_w;
            OP_XOR:  y_d = xor_w;
            OP_SHL:  y_d = shl_w;
            OP_SAR:  y_d = sar_w;
            OP_MUL:  y_d = mul_w;
            OP_SXB:  y_d = sxb_w;
            OP_SXH:  y_d = sxh_w;
            default: y_d = a;
        endcase
    end

    assign y    = y_d;
    assign zero = ~|y_d;
endmodule

// File: rtl/stk_alu_chk.sv
module stk_alu_chk #(
    parameter int W = 32
) (
    input logic [W-1:0] a,
    input logic [W-1:0] b,
    input logic [3:0]   op,
    input logic [W-1:0] y,
    input logic         zero
);
    always_comb begin
        if (op == 4'h0) begin
            p_pass_r1: assert (y == a) else $error("pass-through mismatch");
        end
        if (op == 4'h2) begin
            p_add_wrap_r3: assert (y == W'(a + b)) else $error("add mismatch");
        end
        if (op[3:2] == 2'b01) begin
            p_cmp_bool_r4: assert (y[W-1:1] == '0) else $error("compare not boolean");
        end
        if ((op == 4'h6 || op == 4'h7) && a == b) begin
            p_ucmp_equal_r5: assert (y == '0) else $error("unsigned compare on equal operands");
        end
        if (op == 4'hB && b[4:0] == 5'd0) begin
            p_shl_none_r7: assert (y == a) else $error("zero shift changed value");
        end
        if (op == 4'hC) begin
            p_sar_sign_r8: assert (y[W-1] == a[W-1]) else $error("arith shift lost sign");
        end
        if (op == 4'hE) begin
            p_sxb_fill_r10: assert (y[W-1:8] == {(W-8){a[7]}} && y[7:0] == a[7:0])
                else $error("byte extension wrong");
        end
        if (op == 4'h3 && a == b) begin
            p_sub_zero_r12: assert (zero && y == '0) else $error("equal subtract not zero");
        end
    end
endmodule

bind stk_alu stk_alu_chk #(.W(W)) u_stk_alu_chk (
    .a    (a),
    .b    (b),
    .op   (op),
    .y    (y),
    .zero (zero)
);

// File: tb/stk_alu_bench.sv
`timescale 1ns / 1ps
module stk_alu_bench;

    localparam int W  = 32;
    localparam int NV = 30;

    logic         clk;
    logic         rst_n;
    logic [W-1:0] a, b;
    logic [3:0]   op;
    logic [W-1:0] y;
    logic         zero;

    int checks   = 0;
    int failures = 0;
    bit done     = 0;

    stk_alu #(.W(W)) u_stk_alu (
        .a    (a),
        .b    (b),
        .op   (op),
        .y    (y),
        .zero (zero)
    );

    initial begin
        clk = 1'b0;
        forever #4 clk = ~clk;
    end

    // {req, op, a, b, expected y}
    localparam logic [103:0] VECS [NV] = '{
        {4'd1,  4'h0, 32'h12345678, 32'hFFFFFFFF, 32'h12345678}, // R1
        {4'd2,  4'h1, 32'h0F0F00FF, 32'h00000000, 32'hF0F0FF00}, // R2
        {4'd3,  4'h2, 32'hFFFFFFFF, 32'h00000001, 32'h00000000}, // R3 wrap
        {4'd3,  4'h2, 32'h7FFFFFFF, 32'h00000001, 32'h80000000}, // R3
        {4'd3,  4'h3, 32'h00000000, 32'h00000001, 32'hFFFFFFFF}, // R3 borrow
        {4'd3,  4'h3, 32'h00000010, 32'h00000003, 32'h0000000D}, // R3
        {4'd4,  4'h4, 32'h00000001, 32'hFFFFFFFF, 32'h00000001}, // R4 1 > -1
        {4'd4,  4'h4, 32'h00000005, 32'h00000005, 32'h00000000}, // R4 equal
        {4'd4,  4'h5, 32'h80000000, 32'h7FFFFFFF, 32'h00000001}, // R4 min < max
        {4'd4,  4'h5, 32'h7FFFFFFF, 32'h80000000, 32'h00000000}, // R4
        {4'd5,  4'h6, 32'hFFFFFFFF, 32'h00000001, 32'h00000001}, // R5
        {4'd5,  4'h6, 32'h00000003, 32'h00000003, 32'h00000000}, // R5 equal
        {4'd5,  4'h7, 32'h00000001, 32'hFFFFFFFF, 32'h00000001}, // R5
        {4'd5,  4'h7, 32'hFFFFFFFF, 32'h00000000, 32'h00000000}, // R5
        {4'd6,  4'h8, 32'hF0F0F0F0, 32'hFF00FF00, 32'hF000F000}, // R6
        {4'd6,  4'h9, 32'hF0F0F0F0, 32'hFF00FF00, 32'hFFF0FFF0}, // R6
        {4'd6,  4'hA, 32'hF0F0F0F0, 32'hFF00FF00, 32'h0FF00FF0}, // R6
        {4'd7,  4'hB, 32'h00000001, 32'h0000001F, 32'h80000000}, // R7 max amount
        {4'd7,  4'hB, 32'h00000001, 32'h00000024, 32'h00000010}, // R7 b[31:5] ignored
        {4'd8,  4'hC, 32'h80000000, 32'h00000004, 32'hF8000000}, // R8 sign fill
        {4'd8,  4'hC, 32'h40000000, 32'hFFFFFFFE, 32'h00000001}, // R8 amount 30
        {4'd9,  4'hD, 32'h00010000, 32'h00010000, 32'h00000000}, // R9 truncation
        {4'd9,  4'hD, 32'hFFFFFFFF, 32'hFFFFFFFF, 32'h00000001}, // R9
        {4'd9,  4'hD, 32'h00000007, 32'h00000006, 32'h0000002A}, // R9
        {4'd10, 4'hE, 32'h12345680, 32'h00000000, 32'hFFFFFF80}, // R10
        {4'd10, 4'hE, 32'h0000007F, 32'h00000000, 32'h0000007F}, // R10
        {4'd10, 4'hF, 32'h00008001, 32'h00000000, 32'hFFFF8001}, // R10
        {4'd10, 4'hF, 32'hFFFF7FFF, 32'h00000000, 32'h00007FFF}, // R10
        {4'd11, 4'h1, 32'h0F0F00FF, 32'hDEADBEEF, 32'hF0F0FF00}, // R11 not ignores b
        {4'd11, 4'hF, 32'h00008001, 32'hFFFFFFFF, 32'hFFFF8001}  // R11 sext ignores b
    };

    task automatic check(input string req, input logic [W-1:0] exp_y);
        checks++;
        if (y !== exp_y) begin
            failures++;
            $display("FAIL %s op=%h y actual=%h expected=%h", req, op, y, exp_y);
        end
        checks++;
        // R12: zero flag tracks the result
        if (zero !== (exp_y == '0)) begin
            failures++;
            $display("FAIL R12 (%s) op=%h zero actual=%b expected=%b",
                     req, op, zero, (exp_y == '0));
        end
    endtask

    initial begin
        rst_n = 1'b0;
        a = '0; b = '0; op = 4'h0;
        repeat (3) @(posedge clk);
        @(negedge clk);
        #1;
        check("R1 idle", 32'h0);  // idle state: all-zero inputs
        rst_n = 1'b1;

        for (int i = 0; i < NV; i++) begin
            @(negedge clk);
            op = VECS[i][99:96];
            a  = VECS[i][95:64];
            b  = VECS[i][63:32];
            #1;
            check($sformatf("R%0d", VECS[i][103:100]), VECS[i][31:0]);
        end

        // R13: outputs follow inputs between clock edges
        @(posedge clk);
        #1;
        op = 4'h2; a = 32'd40; b = 32'd2;
        #1;
        check("R13", 32'd42);
        a = 32'd100;
        #1;
        check("R13", 32'd102);

        // R12: subtract of equal values raises zero
        op = 4'h3; a = 32'hA5A5A5A5; b = 32'hA5A5A5A5;
        #1;
        check("R12", 32'h0);

        // R7: only b[4:0] counts, b = 0xFFFFFFE0 means shift by 0
        op = 4'hB; a = 32'h00C0FFEE; b = 32'hFFFFFFE0;
        #1;
        check("R7", 32'h00C0FFEE);

        // R8: positive value shifts in zeros by 31
        op = 4'hC; a = 32'h7FFFFFFF; b = 32'h0000001F;
        #1;
        check("R8", 32'h0);

        done = 1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

    initial begin
        repeat (5000) @(posedge clk);
        if (!done) begin
            checks++;
            failures++;
            $display("FAIL watchdog expired");
            $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    end

endmodule